// File: doc/BRIEF.md
# Timestamped Cluster Sample Packer

This block samples a 16-bit logic input bus and packs the samples into fixed clusters for a capture memory. A cluster is eight 16-bit words: one timestamp word, then seven event words. An event covers one or more base periods of 20 ns. The block clock runs four times faster than the base rate, so one base period is four clock cycles. The channel mode sets how many fast samples of each channel go into one event word. With 16 channels there is one sample per event. With 8 channels there are two samples, 10 ns apart. With 4 channels there are four samples, 5 ns apart. In the multi-sample modes the samples are interleaved channel-major: sample k of channel l sits at bit l*S+k, where S is the number of samples per event.

In the 16-channel mode a fraction value slows the event rate to one event every frac+1 base periods. A free-running timestamp counts base periods. Each finished cluster leaves on a 16-bit valid/ready word stream. If the consumer is still holding the previous cluster when the next one completes, the new cluster is dropped whole and a sticky overflow flag is raised. The cluster already waiting is not corrupted.

The mode code and the fraction are static configuration. They are changed only while reset is held.

Top module: `ts_cluster_packer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `overflow` are 0 after that edge.
- R2: Each cluster leaves as exactly 8 consecutive words: the timestamp word first, then the seven event words in capture order.
- R3: The timestamp advances once per base period (4 clock cycles) and wraps modulo 2^TS_W. The cluster's timestamp word holds the count, zero-extended, of the first base period of the cluster's first event. The first base period after reset is 0.
- R4: Any `mode_code` other than 0xF0 and 0x00 selects 16 channels. The event word equals `din` sampled on the first clock of the event.
- R5: `mode_code` 0x00 selects 8 channels (`din[7:0]`), sampled on clocks 0 and 2 of the base period. Sample k of channel l goes to bit l*2+k.
- R6: `mode_code` 0xF0 selects 4 channels (`din[3:0]`), sampled on every clock of the base period. Sample k of channel l goes to bit l*4+k.
- R7: In 16-channel mode an event spans `frac`+1 base periods. In the other modes `frac` has no effect on the words produced.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. A word advances only on a handshake.
- R9: A cluster that completes while the previous one is still being sent is dropped whole, and `overflow` rises and stays high until reset. The held cluster is delivered intact, and the next cluster delivered is the first to complete after the stream is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four cycles per base period |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 16 | Logic input bus |
| mode_code | input | 8 | Channel mode: 0xF0 = 4 channels, 0x00 = 8 channels, any other value = 16 channels |
| frac | input | FRAC_W | Event-rate fraction, used in 16-channel mode only |
| out_ready | input | 1 | Consumer accepts a word |
| out_valid | output | 1 | A cluster word is on `out_data` |
| out_data | output | 16 | Cluster word stream |
| overflow | output | 1 | Sticky flag: a cluster was dropped |

## Verification
The bench builds the block with TS_W = 6. The timestamp therefore wraps after 64 base periods, and a 4-channel run of eleven clusters observes the wrap within a few hundred cycles. FRAC_W keeps its default of 8, so the slowest fraction, 255, is exercised in full: one cluster spans 7168 clock cycles. EVENTS_PER_CLUSTER stays at 7 to match the fixed cluster format.

// File: rtl/csp_pkg.sv
// Package: shared types and constants for the cluster sample packer.
// Assumes a 16-bit input bus and four clock cycles per base period.
package csp_pkg;
    localparam int WORD_W   = 16;
    localparam int PHASES   = 4;
    localparam int PHASE_W  = $clog2(PHASES);

    typedef enum logic [1:0] {
        MODE_X16 = 2'd0,
        MODE_X8  = 2'd1,
        MODE_X4  = 2'd2
    } chmode_e;

    // Maps the configuration code to a channel mode
    function automatic chmode_e decode_mode(input logic [7:0] code);
        if (code == 8'hF0)      return MODE_X4;
        else if (code == 8'h00) return MODE_X8;
        else                    return MODE_X16;
    endfunction
endpackage

// File: rtl/csp_timer.sv
// Module: clock-phase, fraction divider and base-period timestamp.
// The phase counts clocks inside a base period. The divider groups base
// periods into events (16-channel mode only). The timestamp counts base
// periods and wraps. Assumes the mode and frac stay static outside reset.
module csp_timer
    import csp_pkg::*;
#(
    parameter int TS_W   = 16,
    parameter int FRAC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  chmode_e              mode,
    input  logic [FRAC_W-1:0]    frac,
    output logic [PHASE_W-1:0]   phase,
    output logic                 ev_start,
    output logic                 ev_end,
    output logic [TS_W-1:0]      ts
);
    localparam logic [PHASE_W-1:0] PH_LAST = PHASE_W'(PHASES - 1);

    logic [FRAC_W-1:0] div_q;
    logic [FRAC_W-1:0] frac_eff;

    // Fraction applies only when all sixteen channels are captured
    assign frac_eff = (mode == MODE_X16) ? frac : '0;

    // Event boundaries from the phase and the divider count
    assign ev_start = (phase == '0) && (div_q == '0);
    assign ev_end   = (phase == PH_LAST) && (div_q == frac_eff);

    // Advance phase, divider and timestamp
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            div_q <= '0;
            ts    <= '0;
        end else begin
            phase <= phase + 1'b1;
            if (phase == PH_LAST) begin
                ts    <= ts + 1'b1;
                div_q <= (div_q == frac_eff) ? '0 : div_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/csp_event_builder.sv
// Module: assembles one event word from fast samples.
// Writes sample k of channel l to bit l*S+k. Raises ev_valid for one
// cycle after the event's last clock. While ev_valid is high, ev_word and
// ev_ts still hold the completed event. They are overwritten only at the
// end of that cycle.
module csp_event_builder
    import csp_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  chmode_e              mode,
    input  logic [PHASE_W-1:0]   phase,
    input  logic                 ev_start,
    input  logic                 ev_end,
    input  logic [WORD_W-1:0]    din,
    input  logic [TS_W-1:0]      ts,
    output logic                 ev_valid,
    output logic [WORD_W-1:0]    ev_word,
    output logic [TS_W-1:0]      ev_ts
);
    logic              smp;
    logic [1:0]        k;
    logic [WORD_W-1:0] acc_n;

    // Decide when a sample is taken and which sample slot it fills
    always_comb begin
        smp = 1'b0;
        k   = 2'd0;
        unique case (mode)
            MODE_X4: begin smp = 1'b1;      k = phase;            end
            MODE_X8: begin smp = !phase[0]; k = {1'b0, phase[1]}; end
            default: begin smp = ev_start;  k = 2'd0;             end
        endcase
    end

    // Merge the current sample into the event word, channel-major
    always_comb begin
        acc_n = ev_word;
        if (smp) begin
            unique case (mode)
                MODE_X4: for (int l = 0; l < WORD_W / 4; l++) acc_n[l * 4 + int'(k)] = din[l];
                MODE_X8: for (int l = 0; l < WORD_W / 2; l++) acc_n[l * 2 + int'(k)] = din[l];
                default: acc_n = din;
            endcase
        end
    end

    // Hold the word, the event start time and the completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_word  <= '0;
            ev_ts    <= '0;
            ev_valid <= 1'b0;
        end else begin
            ev_word  <= acc_n;
            ev_valid <= ev_end;
            if (ev_start) ev_ts <= ts;
        end
    end
endmodule

// File: rtl/csp_cluster_packer.sv
// Module: gathers events into clusters and streams them as words.
// Holds one cluster being filled and one being sent. A cluster that
// completes while the send buffer is busy is dropped, and overflow is set.
// Assumes EVENTS_PER_CLUSTER >= 2.
module csp_cluster_packer
    import csp_pkg::*;
#(
    parameter int TS_W               = 16,
    parameter int EVENTS_PER_CLUSTER = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_valid,
    input  logic [WORD_W-1:0]    ev_word,
    input  logic [TS_W-1:0]      ev_ts,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    out_data,
    output logic                 overflow
);
    localparam int OUT_WORDS = EVENTS_PER_CLUSTER + 1;
    localparam int SLOT_W    = $clog2(EVENTS_PER_CLUSTER);
    localparam int IDX_W     = $clog2(OUT_WORDS);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(EVENTS_PER_CLUSTER - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(OUT_WORDS - 1);

    logic [WORD_W-1:0] fill_q [EVENTS_PER_CLUSTER];
    logic [TS_W-1:0]   fill_ts;
    logic [SLOT_W-1:0] slot_q;
    logic [WORD_W-1:0] out_q  [OUT_WORDS];
    logic [IDX_W-1:0]  idx_q;
    logic              busy_q;

    assign out_valid = busy_q;
    assign out_data  = out_q[idx_q];

    // Fill slots, hand complete clusters over, and flag drops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q   <= '0;
            fill_ts  <= '0;
            overflow <= 1'b0;
            busy_q   <= 1'b0;
            idx_q    <= '0;
        end else begin
            if (busy_q && out_ready) begin
                if (idx_q == IDX_LAST) busy_q <= 1'b0;
                else                   idx_q  <= idx_q + 1'b1;
            end
            if (ev_valid) begin
                fill_q[slot_q] <= ev_word;
                if (slot_q == '0) fill_ts <= ev_ts;
                if (slot_q == SLOT_LAST) begin
                    slot_q <= '0;
                    if (!busy_q) begin
                        out_q[0] <= WORD_W'(fill_ts);
                        for (int i = 0; i < EVENTS_PER_CLUSTER - 1; i++)
                            out_q[i + 1] <= fill_q[i];
                        out_q[OUT_WORDS - 1] <= ev_word;
                        busy_q <= 1'b1;
                        idx_q  <= '0;
                    end else begin
                        overflow <= 1'b1;
                    end
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ts_cluster_packer.sv
// Module: top of the timestamped cluster sample packer.
// Decodes the channel mode and chains the timer, the event builder and
// the cluster packer. mode_code and frac are static outside reset.
module ts_cluster_packer
    import csp_pkg::*;
#(
    parameter int TS_W               = 16,
    parameter int FRAC_W             = 8,
    parameter int EVENTS_PER_CLUSTER = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       din,
    input  logic [7:0]        mode_code,
    input  logic [FRAC_W-1:0] frac,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [15:0]       out_data,
    output logic              overflow
);
    chmode_e             mode;
    logic [PHASE_W-1:0]  phase;
    logic                ev_start, ev_end, ev_valid;
    logic [TS_W-1:0]     ts, ev_ts;
    logic [WORD_W-1:0]   ev_word;

    assign mode = decode_mode(mode_code);

    csp_timer #(.TS_W(TS_W), .FRAC_W(FRAC_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .frac(frac),
        .phase(phase), .ev_start(ev_start), .ev_end(ev_end), .ts(ts)
    );

    csp_event_builder #(.TS_W(TS_W)) builder_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .phase(phase),
        .ev_start(ev_start), .ev_end(ev_end), .din(din), .ts(ts),
        .ev_valid(ev_valid), .ev_word(ev_word), .ev_ts(ev_ts)
    );

    csp_cluster_packer #(.TS_W(TS_W), .EVENTS_PER_CLUSTER(EVENTS_PER_CLUSTER)) packer_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_word(ev_word),
        .ev_ts(ev_ts), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .overflow(overflow)
    );
endmodule

// File: rtl/ts_cluster_packer_chk.sv
// Module: protocol checker for the packer's output stream, bound to the top.
module ts_cluster_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        out_ready,
    input logic        out_valid,
    input logic [15:0] out_data,
    input logic        overflow
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !overflow));

    // R8
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R2
    end_on_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_ready));

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9
    overflow_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(out_valid));
endmodule

bind ts_cluster_packer ts_cluster_packer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .overflow(overflow)
);

// File: tb/ts_cluster_packer_tb.sv
// Bench: walks a table of mode/fraction vectors, then runs directed
// overflow and reset tests. Expected words come from a bench-side model.
module ts_cluster_packer_tb_top;
    localparam int TS_W = 6;
    localparam int CAP  = 128;
    // {mode_code, frac, clusters to check}
    localparam logic [23:0] CFG [0:5] = '{
        {8'hF0, 8'd0,   8'd11},
        {8'h00, 8'd0,   8'd3},
        {8'h5A, 8'd0,   8'd3},
        {8'h11, 8'd2,   8'd2},
        {8'h33, 8'd255, 8'd1},
        {8'hF0, 8'd7,   8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = '0;
    logic [7:0]  mode_code = 8'hF0;
    logic [7:0]  frac = '0;
    logic        out_ready = 1'b1;
    logic        out_valid, overflow;
    logic [15:0] out_data;

    int checks = 0;
    int fails = 0;
    int ncnt = 0;
    int cap_n = 0;
    logic [15:0] cap [0:CAP-1];

    always #5 clk = ~clk;

    ts_cluster_packer #(.TS_W(TS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .mode_code(mode_code),
        .frac(frac), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .overflow(overflow)
    );

    function automatic logic [15:0] pat(input int n);
        logic [31:0] x;
        x = 32'(n) * 32'h9E3779B1;
        x = x ^ (x >> 15);
        return x[15:0];
    endfunction

    function automatic logic [15:0] expw(input logic [7:0] code, input int fr, input int c, input int w);
        int s, e, f;
        logic [15:0] r, t;
        s = (code == 8'hF0) ? 4 : (code == 8'h00) ? 2 : 1;
        f = (s == 1) ? fr : 0;
        if (w == 0) return 16'((c * 7 * (f + 1)) % (1 << TS_W));
        e = c * 7 + w - 1;
        if (s == 1) return pat(4 * e * (f + 1));
        r = '0;
        for (int k = 0; k < s; k++) begin
            t = pat(4 * e + k * (4 / s));
            for (int l = 0; l < 16 / s; l++) r[l * s + k] = t[l];
        end
        return r;
    endfunction

    // Drive the sample bus: sample n reaches the n-th edge after reset release
    always @(negedge clk) begin
        din = pat(ncnt);
        if (rst_n) ncnt = ncnt + 1;
        else       ncnt = 0;
    end

    // Record words accepted by a handshake
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && cap_n < CAP) begin
            cap[cap_n] = out_data;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({14'd0, out_valid, overflow}, 16'd0, "R1 reset state");
        @(posedge clk); #1 rst_n = 1'b1;
        cap_n = 0;
    endtask

    task automatic wait_words(input int n);
        int guard = 0;
        while (cap_n < n && guard < 20000) begin
            @(posedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    initial begin
        // Table walk: each mode, fraction and cluster count
        for (int v = 0; v < 6; v++) begin
            mode_code = CFG[v][23:16];
            frac      = CFG[v][15:8];
            out_ready = 1'b1;
            do_reset();
            wait_words(8 * int'(CFG[v][7:0]));
            for (int c = 0; c < int'(CFG[v][7:0]); c++) begin
                for (int w = 0; w < 8; w++) begin
                    string tag;
                    if (w == 0)                    tag = "R2 R3 timestamp";
                    else if (v >= 3)               tag = "R7 fraction";
                    else if (mode_code == 8'hF0)   tag = "R6 four channel";
                    else if (mode_code == 8'h00)   tag = "R5 eight channel";
                    else                           tag = "R4 sixteen channel";
                    chk(cap[c * 8 + w], expw(mode_code, int'(frac), c, w), tag);
                end
            end
            chk({15'd0, overflow}, 16'd0, "R9 no spurious overflow");
        end

        // Directed: stall the stream so later clusters are dropped
        mode_code = 8'hF0;
        frac      = 8'd0;
        out_ready = 1'b0;
        do_reset();
        repeat (100) @(posedge clk);
        @(negedge clk);
        chk({15'd0, overflow}, 16'd1, "R9 overflow raised");
        chk({15'd0, out_valid}, 16'd1, "R8 valid held");
        chk(out_data, expw(8'hF0, 0, 0, 0), "R8 data held");
        @(posedge clk); #1 out_ready = 1'b1;
        wait_words(16);
        for (int w = 0; w < 8; w++) chk(cap[w], expw(8'hF0, 0, 0, w), "R9 held cluster intact");
        for (int w = 0; w < 8; w++) chk(cap[8 + w], expw(8'hF0, 0, 3, w), "R9 next cluster after drop");
        chk({15'd0, overflow}, 16'd1, "R9 overflow sticky");

        // Directed: reset clears the sticky flag and the stream
        do_reset();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule